// File: doc/BRIEF.md
# Hidden Address Latch Unit

This block holds the 16-bit internal address latch that an 8-bit processor core keeps out of sight of the programmer. It sits next to the instruction sequencer. Each time an instruction retires, the sequencer pulses a strobe and presents a decoded operation class, a condition outcome and every 16-bit operand the latch might need. The block picks the source that belongs to the class and loads it. Classes that do not touch the latch leave it unchanged.

The latch value leaks into the flags. When a bit-test on a memory operand addressed through HL retires, the block captures bits 5 and 3 of the latch's high byte and presents them as the two undocumented flag bits. A debug port can overwrite the latch one byte at a time, and the latch is always visible on an output.

Top module: `hidden_addr_latch`

## Requirements
- R1: A synchronous active-high reset clears the latch to 0x0000 and clears both flag outputs to 0.
- R2: Class 1 (indexed access) loads the index register plus the sign-extended 8-bit displacement, wrapping modulo 2^16.
- R3: Class 2 (unconditional absolute jump or call) loads the immediate word.
- R4: Class 3 (conditional absolute jump or call) loads the immediate word whether the condition input is 1 or 0.
- R5: Class 4 (relative jump) with the condition at 1 loads the address after the displacement byte plus the sign-extended displacement, wrapping modulo 2^16. With the condition at 0 the latch is unchanged.
- R6: Class 5 (return: conditional return, or an interrupt return presented with the condition at 1) loads the popped return address when the condition is 1 and leaves the latch unchanged when it is 0.
- R7: Class 6 (restart) loads the vector address, which is the 3-bit restart index times 8.
- R8: Class 7 (nibble rotate through memory) loads HL + 1, wrapping modulo 2^16.
- R9: Class 8 (exchange stack top with a pair) loads the word read from the stack.
- R10: Class 9 (16-bit add) loads the pre-operation destination pair + 1, and class 10 (16-bit add-with-carry or subtract-with-borrow) loads the pre-operation HL + 1, both wrapping modulo 2^16.
- R11: Class 11 (memory bit-test through HL) leaves the latch unchanged. One cycle after the strobe, flag output bit 1 equals latch bit 13 and flag output bit 0 equals latch bit 11. The flag outputs hold their value until the next class 11 retirement.
- R12: Class 0 and codes 12 to 15 leave the latch and the flag outputs unchanged. Inputs are ignored in any cycle without the strobe.
- R13: A debug write loads only the bytes whose enable bit is set: enable bit 0 selects bits 7:0 and enable bit 1 selects bits 15:8.
- R14: When a debug write and a retirement strobe fall in the same cycle, the debug write wins and the instruction's latch update is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| retire_i | input | 1 | Instruction-complete strobe |
| op_class_i | input | 4 | Decoded operation class |
| cond_i | input | 1 | Condition outcome (1 = taken) |
| imm_word_i | input | 16 | 16-bit immediate operand |
| pc_next_i | input | 16 | Address following the displacement byte |
| pop_word_i | input | 16 | Return address popped from the stack |
| hl_i | input | 16 | HL before the operation |
| dst_pair_i | input | 16 | Destination pair before the operation |
| idx_reg_i | input | 16 | Index register |
| disp_i | input | 8 | Signed displacement |
| rst_idx_i | input | 3 | Restart index |
| stk_word_i | input | 16 | Word read from the stack top |
| dbg_wr_i | input | 1 | Debug write strobe |
| dbg_be_i | input | 2 | Debug byte enables |
| dbg_wdata_i | input | 16 | Debug write data |
| latch_o | output | 16 | Current latch value (debug read) |
| bit_flags_o | output | 2 | Leaked flag bits {bit5, bit3} |

## Verification
The assertions assume that the class code and all operands are stable and meaningful in any cycle where the strobe is high. They also assume that an unconditional return is presented as class 5 with the condition at 1. The bench drives every input at the falling edge and holds it for exactly one strobe cycle. It sets the condition explicitly for each conditional class, and it scrambles all operand inputs when it drives no-effect classes and idle cycles, so that any leak would show up at the latch output.

// File: rtl/hal_pkg.sv
package hal_pkg;
  typedef enum logic [3:0] {
    OP_NONE   = 4'd0,
    OP_INDEX  = 4'd1,
    OP_JABS   = 4'd2,
    OP_JCOND  = 4'd3,
    OP_JREL   = 4'd4,
    OP_RET    = 4'd5,
    OP_RSTV   = 4'd6,
    OP_NIBROT = 4'd7,
    OP_EXSP   = 4'd8,
    OP_ADD16  = 4'd9,
    OP_ADCSBC = 4'd10,
    OP_BITMEM = 4'd11
  } op_class_t;
endpackage

// File: rtl/hal_addr_calc.sv
module hal_addr_calc #(
  parameter int AW        = 16,
  parameter int DISP_W    = 8,
  parameter int RST_W     = 3,
  parameter int RST_SHIFT = 3
) (
  input  logic [AW-1:0]     pc_next_i,
  input  logic [AW-1:0]     hl_i,
  input  logic [AW-1:0]     dst_pair_i,
  input  logic [AW-1:0]     idx_reg_i,
  input  logic [DISP_W-1:0] disp_i,
  input  logic [RST_W-1:0]  rst_idx_i,
  output logic [AW-1:0]     index_ea_o,
  output logic [AW-1:0]     rel_tgt_o,
  output logic [AW-1:0]     hl_inc_o,
  output logic [AW-1:0]     dst_inc_o,
  output logic [AW-1:0]     rst_vec_o
);
  localparam int EXT_W = AW - DISP_W;
  localparam int PAD_W = AW - RST_W - RST_SHIFT;

  logic [AW-1:0] disp_sx;

  always_comb begin
    disp_sx    = {{EXT_W{disp_i[DISP_W-1]}}, disp_i};
    index_ea_o = idx_reg_i + disp_sx;
    rel_tgt_o  = pc_next_i + disp_sx;
    hl_inc_o   = hl_i + AW'(1);
    dst_inc_o  = dst_pair_i + AW'(1);
    rst_vec_o  = {{PAD_W{1'b0}}, rst_idx_i, {RST_SHIFT{1'b0}}};
  end
endmodule

// File: rtl/hal_src_select.sv
module hal_src_select #(
  parameter int AW = 16
) (
  input  logic [3:0]    op_class_i,
  input  logic          cond_i,
  input  logic [AW-1:0] imm_word_i,
  input  logic [AW-1:0] pop_word_i,
  input  logic [AW-1:0] stk_word_i,
  input  logic [AW-1:0] index_ea_i,
  input  logic [AW-1:0] rel_tgt_i,
  input  logic [AW-1:0] hl_inc_i,
  input  logic [AW-1:0] dst_inc_i,
  input  logic [AW-1:0] rst_vec_i,
  output logic          load_o,
  output logic [AW-1:0] value_o,
  output logic          bit_test_o
);
  import hal_pkg::*;

  always_comb begin
    load_o     = 1'b0;
    value_o    = '0;
    bit_test_o = 1'b0;
    unique case (op_class_i)
      OP_INDEX:  begin load_o = 1'b1;   value_o = index_ea_i; end
      OP_JABS:   begin load_o = 1'b1;   value_o = imm_word_i; end
      OP_JCOND:  begin load_o = 1'b1;   value_o = imm_word_i; end
      OP_JREL:   begin load_o = cond_i; value_o = rel_tgt_i;  end
      OP_RET:    begin load_o = cond_i; value_o = pop_word_i; end
      OP_RSTV:   begin load_o = 1'b1;   value_o = rst_vec_i;  end
      OP_NIBROT: begin load_o = 1'b1;   value_o = hl_inc_i;   end
      OP_EXSP:   begin load_o = 1'b1;   value_o = stk_word_i; end
      OP_ADD16:  begin load_o = 1'b1;   value_o = dst_inc_i;  end
      OP_ADCSBC: begin load_o = 1'b1;   value_o = hl_inc_i;   end
      OP_BITMEM: bit_test_o = 1'b1;
      default:   ;
    endcase
  end
endmodule

// File: rtl/hal_latch_store.sv
module hal_latch_store #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_i,
  input  logic [AW-1:0] value_i,
  input  logic          dbg_wr_i,
  input  logic [AW/8-1:0] dbg_be_i,
  input  logic [AW-1:0] dbg_wdata_i,
  output logic [AW-1:0] latch_o
);
  localparam int NB = AW / 8;

  for (genvar b = 0; b < NB; b++) begin : g_byte
    always_ff @(posedge clk) begin
      if (rst) begin
        latch_o[b*8 +: 8] <= 8'h00;
      end else if (dbg_wr_i) begin
        if (dbg_be_i[b]) latch_o[b*8 +: 8] <= dbg_wdata_i[b*8 +: 8];
      end else if (load_i) begin
        latch_o[b*8 +: 8] <= value_i[b*8 +: 8];
      end
    end
  end
endmodule

// File: rtl/hal_flag_tap.sv
module hal_flag_tap #(
  parameter int AW      = 16,
  parameter int BIT_HI  = 5,
  parameter int BIT_LO  = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          capture_i,
  input  logic [AW-1:0] latch_i,
  output logic [1:0]    flags_o
);
  localparam int HB = AW - 8;

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_o <= 2'b00;
    end else if (capture_i) begin
      flags_o <= {latch_i[HB+BIT_HI], latch_i[HB+BIT_LO]};
    end
  end
endmodule

// File: rtl/hidden_addr_latch.sv
module hidden_addr_latch #(
  parameter int AW        = 16,
  parameter int DISP_W    = 8,
  parameter int RST_W     = 3,
  parameter int RST_SHIFT = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              retire_i,
  input  logic [3:0]        op_class_i,
  input  logic              cond_i,
  input  logic [AW-1:0]     imm_word_i,
  input  logic [AW-1:0]     pc_next_i,
  input  logic [AW-1:0]     pop_word_i,
  input  logic [AW-1:0]     hl_i,
  input  logic [AW-1:0]     dst_pair_i,
  input  logic [AW-1:0]     idx_reg_i,
  input  logic [DISP_W-1:0] disp_i,
  input  logic [RST_W-1:0]  rst_idx_i,
  input  logic [AW-1:0]     stk_word_i,
  input  logic              dbg_wr_i,
  input  logic [AW/8-1:0]   dbg_be_i,
  input  logic [AW-1:0]     dbg_wdata_i,
  output logic [AW-1:0]     latch_o,
  output logic [1:0]        bit_flags_o
);
  logic [AW-1:0] index_ea, rel_tgt, hl_inc, dst_inc, rst_vec, sel_val;
  logic          sel_load, sel_bit;

  hal_addr_calc #(.AW(AW), .DISP_W(DISP_W), .RST_W(RST_W), .RST_SHIFT(RST_SHIFT)) u_calc (
    .pc_next_i(pc_next_i), .hl_i(hl_i), .dst_pair_i(dst_pair_i),
    .idx_reg_i(idx_reg_i), .disp_i(disp_i), .rst_idx_i(rst_idx_i),
    .index_ea_o(index_ea), .rel_tgt_o(rel_tgt), .hl_inc_o(hl_inc),
    .dst_inc_o(dst_inc), .rst_vec_o(rst_vec)
  );

  hal_src_select #(.AW(AW)) u_sel (
    .op_class_i(op_class_i), .cond_i(cond_i), .imm_word_i(imm_word_i),
    .pop_word_i(pop_word_i), .stk_word_i(stk_word_i), .index_ea_i(index_ea),
    .rel_tgt_i(rel_tgt), .hl_inc_i(hl_inc), .dst_inc_i(dst_inc),
    .rst_vec_i(rst_vec), .load_o(sel_load), .value_o(sel_val),
    .bit_test_o(sel_bit)
  );

  hal_latch_store #(.AW(AW)) u_store (
    .clk(clk), .rst(rst), .load_i(retire_i & sel_load), .value_i(sel_val),
    .dbg_wr_i(dbg_wr_i), .dbg_be_i(dbg_be_i), .dbg_wdata_i(dbg_wdata_i),
    .latch_o(latch_o)
  );

  hal_flag_tap #(.AW(AW)) u_flags (
    .clk(clk), .rst(rst), .capture_i(retire_i & sel_bit),
    .latch_i(latch_o), .flags_o(bit_flags_o)
  );
endmodule

// File: rtl/hal_checker.sv
module hal_checker #(
  parameter int AW = 16
) (
  input logic            clk,
  input logic            rst,
  input logic            retire_i,
  input logic [3:0]      op_class_i,
  input logic            cond_i,
  input logic [AW-1:0]   imm_word_i,
  input logic            dbg_wr_i,
  input logic [AW/8-1:0] dbg_be_i,
  input logic [AW-1:0]   latch_o,
  input logic [1:0]      bit_flags_o
);
  import hal_pkg::*;

  // R1: reset clears the latch
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (latch_o == '0 && bit_flags_o == 2'b00));

  // R4: conditional absolute transfer loads the immediate regardless of condition
  assert_jcond_loads_R4: assert property (@(posedge clk) disable iff (rst)
    (retire_i && !dbg_wr_i && op_class_i == OP_JCOND) |=> latch_o == $past(imm_word_i));

  // R5/R6: untaken relative jump or return keeps the latch
  assert_untaken_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (retire_i && !dbg_wr_i && !cond_i && (op_class_i == OP_JREL || op_class_i == OP_RET))
    |=> $stable(latch_o));

  // R11: memory bit-test exposes latch bits 13 and 11
  assert_bit_leak_R11: assert property (@(posedge clk) disable iff (rst)
    (retire_i && !dbg_wr_i && op_class_i == OP_BITMEM)
    |=> (bit_flags_o == {$past(latch_o[AW-3]), $past(latch_o[AW-5])} && $stable(latch_o)));

  // R12: idle cycles change neither latch nor flags
  assert_idle_hold_R12: assert property (@(posedge clk) disable iff (rst)
    (!retire_i && !dbg_wr_i) |=> ($stable(latch_o) && $stable(bit_flags_o)));

  // R13: a debug write with only the high enable keeps the low byte
  assert_dbg_lo_keep_R13: assert property (@(posedge clk) disable iff (rst)
    (dbg_wr_i && !dbg_be_i[0]) |=> latch_o[7:0] == $past(latch_o[7:0]));
endmodule

bind hidden_addr_latch hal_checker #(.AW(AW)) u_hal_checker (
  .clk(clk), .rst(rst), .retire_i(retire_i), .op_class_i(op_class_i),
  .cond_i(cond_i), .imm_word_i(imm_word_i), .dbg_wr_i(dbg_wr_i),
  .dbg_be_i(dbg_be_i), .latch_o(latch_o), .bit_flags_o(bit_flags_o)
);

// File: tb/tb_hidden_addr_latch.sv
module tb_hidden_addr_latch;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        retire_i = 1'b0;
  logic [3:0]  op_class_i = '0;
  logic        cond_i = 1'b0;
  logic [15:0] imm_word_i = '0, pc_next_i = '0, pop_word_i = '0, hl_i = '0;
  logic [15:0] dst_pair_i = '0, idx_reg_i = '0, stk_word_i = '0, dbg_wdata_i = '0;
  logic [7:0]  disp_i = '0;
  logic [2:0]  rst_idx_i = '0;
  logic        dbg_wr_i = 1'b0;
  logic [1:0]  dbg_be_i = '0;
  logic [15:0] latch_o;
  logic [1:0]  bit_flags_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [15:0] q_latch[$];
  logic [1:0]  q_flags[$];
  string       q_tag[$];
  logic [15:0] m_latch = 16'h0000;
  logic [1:0]  m_flags = 2'b00;

  always #(CLK_PERIOD/2) clk = ~clk;

  hidden_addr_latch dut (
    .clk(clk), .rst(rst), .retire_i(retire_i), .op_class_i(op_class_i),
    .cond_i(cond_i), .imm_word_i(imm_word_i), .pc_next_i(pc_next_i),
    .pop_word_i(pop_word_i), .hl_i(hl_i), .dst_pair_i(dst_pair_i),
    .idx_reg_i(idx_reg_i), .disp_i(disp_i), .rst_idx_i(rst_idx_i),
    .stk_word_i(stk_word_i), .dbg_wr_i(dbg_wr_i), .dbg_be_i(dbg_be_i),
    .dbg_wdata_i(dbg_wdata_i), .latch_o(latch_o), .bit_flags_o(bit_flags_o)
  );

  task automatic scramble(input logic [15:0] s);
    imm_word_i = s ^ 16'h1111; pc_next_i = s ^ 16'h2222; pop_word_i = s ^ 16'h3333;
    hl_i = s ^ 16'h4444; dst_pair_i = s ^ 16'h5555; idx_reg_i = s ^ 16'h6666;
    stk_word_i = s ^ 16'h7777; disp_i = s[7:0]; rst_idx_i = s[2:0];
    cond_i = s[0];
  endtask

  task automatic push_exp(input string tag);
    q_latch.push_back(m_latch);
    q_flags.push_back(m_flags);
    q_tag.push_back(tag);
  endtask

  // one retirement; caller has set operand inputs and the model
  task automatic retire(input logic [3:0] op, input logic c, input logic [15:0] exp_l,
                        input logic [1:0] exp_f, input string tag);
    @(negedge clk);
    op_class_i = op; cond_i = c; retire_i = 1'b1;
    @(posedge clk);
    #1;
    retire_i = 1'b0;
    scramble(16'hC3A5 ^ exp_l);
    m_latch = exp_l; m_flags = exp_f;
    push_exp(tag);
  endtask

  task automatic dbg_write(input logic [1:0] be, input logic [15:0] d, input logic [15:0] exp_l,
                           input string tag);
    @(negedge clk);
    dbg_wr_i = 1'b1; dbg_be_i = be; dbg_wdata_i = d;
    @(posedge clk);
    #1;
    dbg_wr_i = 1'b0; dbg_be_i = '0;
    m_latch = exp_l;
    push_exp(tag);
  endtask

  // monitor: compare at the falling edge after each result
  initial begin
    forever begin
      @(negedge clk);
      while (q_tag.size() > 0) begin
        logic [15:0] el;
        logic [1:0]  ef;
        string t;
        el = q_latch.pop_front(); ef = q_flags.pop_front(); t = q_tag.pop_front();
        checks++;
        if (latch_o !== el || bit_flags_o !== ef) begin
          failures++;
          $display("FAIL %s latch=%h flags=%b expected latch=%h flags=%b",
                   t, latch_o, bit_flags_o, el, ef);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    scramble(16'h9A5B);
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    push_exp("R1 reset state");

    // R2 indexed, negative displacement and wrap
    idx_reg_i = 16'h1000; disp_i = 8'h80;
    retire(4'd1, 1'b0, 16'h0F80, m_flags, "R2 index neg disp");
    idx_reg_i = 16'hFFF0; disp_i = 8'h20;
    retire(4'd1, 1'b1, 16'h0010, m_flags, "R2 index wrap");
    // R3
    imm_word_i = 16'h1234;
    retire(4'd2, 1'b0, 16'h1234, m_flags, "R3 absolute jump");
    // R4 not taken and taken
    imm_word_i = 16'hBEEF;
    retire(4'd3, 1'b0, 16'hBEEF, m_flags, "R4 cond untaken");
    imm_word_i = 16'h0102;
    retire(4'd3, 1'b1, 16'h0102, m_flags, "R4 cond taken");
    // R5
    pc_next_i = 16'h2000; disp_i = 8'hFE;
    retire(4'd4, 1'b1, 16'h1FFE, m_flags, "R5 rel taken");
    pc_next_i = 16'h5555; disp_i = 8'h10;
    retire(4'd4, 1'b0, 16'h1FFE, m_flags, "R5 rel untaken");
    // R6
    pop_word_i = 16'h4567;
    retire(4'd5, 1'b1, 16'h4567, m_flags, "R6 return taken");
    pop_word_i = 16'h9999;
    retire(4'd5, 1'b0, 16'h4567, m_flags, "R6 return untaken");
    // R7
    rst_idx_i = 3'd7;
    retire(4'd6, 1'b0, 16'h0038, m_flags, "R7 restart 7");
    rst_idx_i = 3'd1;
    retire(4'd6, 1'b0, 16'h0008, m_flags, "R7 restart 1");
    // R8
    hl_i = 16'hFFFF;
    retire(4'd7, 1'b0, 16'h0000, m_flags, "R8 nibble rotate wrap");
    // R9
    stk_word_i = 16'hA5C3;
    retire(4'd8, 1'b0, 16'hA5C3, m_flags, "R9 exchange stack");
    // R10
    dst_pair_i = 16'h7FFF; hl_i = 16'h1111;
    retire(4'd9, 1'b0, 16'h8000, m_flags, "R10 add16 dest+1");
    hl_i = 16'h00FF; dst_pair_i = 16'h3333;
    retire(4'd10, 1'b1, 16'h0100, m_flags, "R10 adc/sbc hl+1");
    // R13 byte writes
    dbg_write(2'b10, 16'h28EE, 16'h2800, "R13 debug high byte");
    dbg_write(2'b01, 16'hFF3C, 16'h283C, "R13 debug low byte");
    // R11 leak
    retire(4'd11, 1'b0, 16'h283C, 2'b11, "R11 bit-test flags 11");
    dbg_write(2'b11, 16'h20FF, 16'h20FF, "R13 debug both bytes");
    retire(4'd11, 1'b1, 16'h20FF, 2'b10, "R11 bit-test flags 10");
    dbg_write(2'b10, 16'h0800, 16'h08FF, "R13 debug high only");
    retire(4'd11, 1'b0, 16'h08FF, 2'b01, "R11 bit-test flags 01");
    // R12 no-effect classes and idle cycles
    retire(4'd0, 1'b1, 16'h08FF, 2'b01, "R12 class 0");
    retire(4'd12, 1'b1, 16'h08FF, 2'b01, "R12 code 12");
    retire(4'd15, 1'b0, 16'h08FF, 2'b01, "R12 code 15");
    @(negedge clk);
    op_class_i = 4'd2; imm_word_i = 16'hDEAD;
    repeat (3) @(negedge clk);
    push_exp("R12 idle no strobe");
    // R14 debug wins over retirement
    @(negedge clk);
    op_class_i = 4'd2; imm_word_i = 16'h7777; retire_i = 1'b1;
    dbg_wr_i = 1'b1; dbg_be_i = 2'b01; dbg_wdata_i = 16'h00AA;
    @(posedge clk);
    #1;
    retire_i = 1'b0; dbg_wr_i = 1'b0; dbg_be_i = '0;
    m_latch = 16'h08AA;
    push_exp("R14 debug priority");
    // R1 reset again
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #1 rst = 1'b0;
    m_latch = 16'h0000; m_flags = 2'b00;
    push_exp("R1 reset clears");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule